// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block runs an external 12-bit analog-to-digital converter for a host that talks over an 8-bit register bus with four byte offsets. A command register selects what starts a conversion. The choices are a host write, a qualified pulse on an asynchronous external trigger pin, or a tick from a periodic timer. The timer tick can optionally be ANDed with the synchronized external level. While a conversion runs, the end-of-conversion flag is high and the sample-and-hold is kept in hold. Any further start request is dropped until the converter reports completion.

On completion the 12-bit result is captured. It stays unchanged until the next completion, and the host reads it as a low byte and a high byte. The completion event raises an interrupt line, a DMA request, or both, according to two enable bits. A channel register drives the converter's multiplexer address. It is limited to 0..15 when the single-ended jumper input is low and to 0..7 when the differential input is high.

The converter's result enters on `adc_data` qualified by `adc_done`. This is a valid strobe with no ready, because the block accepts it whenever a conversion is outstanding and ignores it otherwise. The DMA request is a valid/ready pair: `dma_req` stays high until a cycle with `dma_ack` high. If a later conversion completes before that acknowledge, the request simply stays high and the captured result is replaced.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the command and channel registers, the result, `eoc`, `sh_hold`, `adc_start`, `irq` and `dma_req` are all zero.
- R2: Command bits [1:0] select the start source: 00 host write, 01 external pin, 10 timer, 11 none. In host-write mode, a write of any data to offset 0 starts a conversion. On the clock edge that accepts a start, `eoc` and `sh_hold` rise and `adc_start` is high for exactly one cycle. Writes to offset 0 in other modes start nothing.
- R3: In external mode the pin passes through a two-flop synchronizer. A start fires only when the synchronized level has stayed high for more than MIN_PULSE_NS, which is 11 clock cycles at the default 20 ns period. It fires once per high period. A pulse of 10 cycles or fewer is ignored. The pin has no effect in host-write mode.
- R4: In timer mode each `tmr_tick` starts a conversion. When command bit 2 is set, a tick only starts a conversion while the synchronized external level is high.
- R5: A start request from any source that arrives while `eoc` is high is discarded. It produces no `adc_start` pulse.
- R6: `adc_done` while `eoc` is high captures `adc_data` and clears `eoc` and `sh_hold`. `adc_done` while `eoc` is low is ignored. The captured result changes only at a completion. Offset 0 reads result bits [7:0], and offset 1 reads {4'b0, result[11:8]}.
- R7: With command bit 3 set, a completion sets `irq`. It stays high until the host reads offset 1. With bit 3 clear, no `irq` is raised.
- R8: With command bit 4 set, a completion sets `dma_req`. It stays high until a cycle with `dma_ack` high. With bit 4 clear, no request is raised.
- R9: A write to offset 2 stores wdata[3:0] as the channel in single-ended mode, or {0, wdata[2:0]} in differential mode. The stored channel drives `adc_chan`. Offset 2 reads {3'b0, cfg_diff, channel}.
- R10: Offset 3 reads {eoc, 2'b00, command[4:0]}. Command writes take wdata[4:0].
- R11: In mode 11, no host write, external pulse or timer tick starts a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_diff | input | 1 | Jumper: 1 selects differential inputs |
| host_addr | input | 2 | Register offset |
| host_wr_en | input | 1 | Register write strobe |
| host_rd_en | input | 1 | Register read strobe (clears irq on offset 1) |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for host_addr, combinational |
| ext_trig | input | 1 | Asynchronous external trigger / gate |
| tmr_tick | input | 1 | One-cycle tick from the interval timer |
| adc_start | output | 1 | One-cycle start pulse to the converter |
| adc_chan | output | 4 | Multiplexer channel address |
| adc_done | input | 1 | Converter completion strobe (valid) |
| adc_data | input | 12 | Converter result, valid with adc_done |
| eoc | output | 1 | Conversion in progress |
| sh_hold | output | 1 | Sample-and-hold in hold |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request (valid) |
| dma_ack | input | 1 | DMA acknowledge (ready) |

## Verification
On every cycle the assertions check several rules. A start pulse appears only as `eoc` leaves idle. A completion always ends the conversion. The captured result moves only when `eoc` falls. An interrupt only rises with that fall. A DMA request is held until acknowledged. Only the bench's scenarios can show the pulse-width boundary of the external trigger, the gating of timer ticks, the channel masking in each input mode, the byte split of the result across a sweep of values, and that each source is inert outside its mode.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    TRIG_SW  = 2'b00,
    TRIG_EXT = 2'b01,
    TRIG_TMR = 2'b10,
    TRIG_OFF = 2'b11
  } trig_mode_e;

  // Field order sets the bit positions the host writes: mode at [1:0].
  typedef struct packed {
    logic       dma_en;   // [4]
    logic       irq_en;   // [3]
    logic       gate_en;  // [2]
    trig_mode_e mode;     // [1:0]
  } cmd_t;

  localparam int CMD_W = $bits(cmd_t);

  localparam logic [1:0] OFS_DATA_LO = 2'd0;
  localparam logic [1:0] OFS_DATA_HI = 2'd1;
  localparam logic [1:0] OFS_CHAN    = 2'd2;
  localparam logic [1:0] OFS_CMD     = 2'd3;

endpackage

// File: rtl/adc_ext_qual.sv
module adc_ext_qual #(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_CYC    = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_async,
  output logic ext_level,
  output logic ext_fire
);
  localparam int CNT_W = $clog2(QUAL_CYC + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       hi_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], ext_async};
  end

  assign ext_level = sync_q[SYNC_STAGES-1];

  // Counts consecutive high cycles, saturating so one level fires once.
  always_ff @(posedge clk) begin
    if (!rst_n)                          hi_cnt <= '0;
    else if (!ext_level)                 hi_cnt <= '0;
    else if (hi_cnt != CNT_W'(QUAL_CYC)) hi_cnt <= hi_cnt + 1'b1;
  end

  assign ext_fire = ext_level && (hi_cnt == CNT_W'(QUAL_CYC - 1));

endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
  import adc_seq_pkg::*;
(
  input  cmd_t cmd,
  input  logic sw_write,
  input  logic ext_fire,
  input  logic ext_level,
  input  logic tmr_tick,
  output logic start_req
);
  always_comb begin
    unique case (cmd.mode)
      TRIG_SW:  start_req = sw_write;
      TRIG_EXT: start_req = ext_fire;
      TRIG_TMR: start_req = tmr_tick && (!cmd.gate_en || ext_level);
      default:  start_req = 1'b0;
    endcase
  end
endmodule

// File: rtl/adc_conv_ctl.sv
module adc_conv_ctl #(
  parameter int ADC_BITS = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_req,
  input  logic                adc_done,
  input  logic [ADC_BITS-1:0] adc_data,
  input  logic                irq_en,
  input  logic                dma_en,
  input  logic                irq_clr,
  input  logic                dma_ack,
  output logic                adc_start,
  output logic                eoc,
  output logic [ADC_BITS-1:0] result,
  output logic                irq,
  output logic                dma_req
);
  logic accept_start;
  logic finish;

  assign accept_start = start_req && !eoc;
  assign finish       = eoc && adc_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eoc       <= 1'b0;
      adc_start <= 1'b0;
      result    <= '0;
    end else begin
      adc_start <= accept_start;
      if (accept_start) begin
        eoc <= 1'b1;
      end else if (finish) begin
        eoc    <= 1'b0;
        result <= adc_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                irq <= 1'b0;
    else if (finish && irq_en) irq <= 1'b1;
    else if (irq_clr)          irq <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                dma_req <= 1'b0;
    else if (finish && dma_en) dma_req <= 1'b1;
    else if (dma_ack)          dma_req <= 1'b0;
  end

endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int BUS_W    = 8,
  parameter int ADC_BITS = 12,
  parameter int CHAN_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_diff,
  input  logic [1:0]          host_addr,
  input  logic                host_wr_en,
  input  logic                host_rd_en,
  input  logic [BUS_W-1:0]    host_wdata,
  input  logic [ADC_BITS-1:0] result,
  input  logic                eoc,
  output cmd_t                cmd,
  output logic [CHAN_W-1:0]   chan,
  output logic                sw_write,
  output logic                irq_clr,
  output logic [BUS_W-1:0]    host_rdata
);
  localparam int HI_W = ADC_BITS - BUS_W;

  logic [CHAN_W-1:0] chan_wr;

  // Differential mode has half the channels: the top address bit is dropped.
  assign chan_wr = cfg_diff ? {1'b0, host_wdata[CHAN_W-2:0]} : host_wdata[CHAN_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd  <= '0;
      chan <= '0;
    end else if (host_wr_en) begin
      if (host_addr == OFS_CMD)  cmd  <= cmd_t'(host_wdata[CMD_W-1:0]);
      if (host_addr == OFS_CHAN) chan <= chan_wr;
    end
  end

  assign sw_write = host_wr_en && (host_addr == OFS_DATA_LO);
  assign irq_clr  = host_rd_en && (host_addr == OFS_DATA_HI);

  always_comb begin
    host_rdata = '0;
    unique case (host_addr)
      OFS_DATA_LO: host_rdata = result[BUS_W-1:0];
      OFS_DATA_HI: host_rdata[HI_W-1:0] = result[ADC_BITS-1:BUS_W];
      OFS_CHAN: begin
        host_rdata[CHAN_W-1:0] = chan;
        host_rdata[CHAN_W]     = cfg_diff;
      end
      default: begin
        host_rdata[CMD_W-1:0] = cmd;
        host_rdata[BUS_W-1]   = eoc;
      end
    endcase
  end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int BUS_W         = 8,
  parameter int ADC_BITS      = 12,
  parameter int CHAN_W        = 4,
  parameter int CLK_PERIOD_NS = 20,
  parameter int MIN_PULSE_NS  = 200,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_diff,
  input  logic [1:0]          host_addr,
  input  logic                host_wr_en,
  input  logic                host_rd_en,
  input  logic [BUS_W-1:0]    host_wdata,
  output logic [BUS_W-1:0]    host_rdata,
  input  logic                ext_trig,
  input  logic                tmr_tick,
  output logic                adc_start,
  output logic [CHAN_W-1:0]   adc_chan,
  input  logic                adc_done,
  input  logic [ADC_BITS-1:0] adc_data,
  output logic                eoc,
  output logic                sh_hold,
  output logic                irq,
  output logic                dma_req,
  input  logic                dma_ack
);
  // Strictly longer than the minimum: one cycle past the whole-period count.
  localparam int QUAL_CYC = MIN_PULSE_NS / CLK_PERIOD_NS + 1;

  cmd_t                cmd;
  logic [CHAN_W-1:0]   chan_q;
  logic [ADC_BITS-1:0] result_q;
  logic                sw_write;
  logic                irq_clr;
  logic                ext_level;
  logic                ext_fire;
  logic                start_req;

  adc_seq_regs #(
    .BUS_W(BUS_W), .ADC_BITS(ADC_BITS), .CHAN_W(CHAN_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_diff(cfg_diff),
    .host_addr(host_addr), .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
    .host_wdata(host_wdata), .result(result_q), .eoc(eoc),
    .cmd(cmd), .chan(chan_q), .sw_write(sw_write), .irq_clr(irq_clr),
    .host_rdata(host_rdata)
  );

  adc_ext_qual #(
    .SYNC_STAGES(SYNC_STAGES), .QUAL_CYC(QUAL_CYC)
  ) u_qual (
    .clk(clk), .rst_n(rst_n), .ext_async(ext_trig),
    .ext_level(ext_level), .ext_fire(ext_fire)
  );

  adc_trig_sel u_trig (
    .cmd(cmd), .sw_write(sw_write), .ext_fire(ext_fire),
    .ext_level(ext_level), .tmr_tick(tmr_tick), .start_req(start_req)
  );

  adc_conv_ctl #(
    .ADC_BITS(ADC_BITS)
  ) u_conv (
    .clk(clk), .rst_n(rst_n), .start_req(start_req),
    .adc_done(adc_done), .adc_data(adc_data),
    .irq_en(cmd.irq_en), .dma_en(cmd.dma_en),
    .irq_clr(irq_clr), .dma_ack(dma_ack),
    .adc_start(adc_start), .eoc(eoc), .result(result_q),
    .irq(irq), .dma_req(dma_req)
  );

  assign adc_chan = chan_q;
  assign sh_hold  = eoc;

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int ADC_BITS = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                adc_start,
  input logic                eoc,
  input logic                adc_done,
  input logic [ADC_BITS-1:0] result,
  input logic                irq,
  input logic                dma_req,
  input logic                dma_ack
);
  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> (eoc && !$past(eoc)));                                  // R5
  AST_EOC_RISE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoc) |-> adc_start);                                            // R2
  AST_DONE_ENDS_EOC: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && adc_done) |=> !eoc);                                          // R6
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(eoc) |-> $stable(result));                                     // R6
  AST_IRQ_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $fell(eoc));                                           // R7
  AST_DMA_WAITS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !dma_ack) |=> dma_req);                                   // R8
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.ADC_BITS(ADC_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .adc_start(adc_start), .eoc(eoc),
  .adc_done(adc_done), .result(result_q), .irq(irq),
  .dma_req(dma_req), .dma_ack(dma_ack)
);

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_diff = 1'b0;
  logic [1:0]  host_addr = '0;
  logic        host_wr_en = 1'b0;
  logic        host_rd_en = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        ext_trig = 1'b0;
  logic        tmr_tick = 1'b0;
  logic        adc_start;
  logic [3:0]  adc_chan;
  logic        adc_done = 1'b0;
  logic [11:0] adc_data = '0;
  logic        eoc, sh_hold, irq, dma_req;
  logic        dma_ack = 1'b0;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  adc_seq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_diff(cfg_diff), .host_addr(host_addr),
    .host_wr_en(host_wr_en), .host_rd_en(host_rd_en), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .ext_trig(ext_trig), .tmr_tick(tmr_tick),
    .adc_start(adc_start), .adc_chan(adc_chan), .adc_done(adc_done),
    .adc_data(adc_data), .eoc(eoc), .sh_hold(sh_hold), .irq(irq),
    .dma_req(dma_req), .dma_ack(dma_ack)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr_en = 1'b1;
    @(posedge clk); #2 host_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk); host_addr = a; host_rd_en = 1'b1;
    #2 v = int'(host_rdata);
    @(posedge clk); #2 host_rd_en = 1'b0;
  endtask

  task automatic finish_conv(input logic [11:0] v);
    @(negedge clk); adc_data = v; adc_done = 1'b1;
    @(posedge clk); #2 adc_done = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); tmr_tick = 1'b1;
    @(posedge clk); #2 tmr_tick = 1'b0;
  endtask

  task automatic ext_pulse(input int k);
    @(negedge clk); ext_trig = 1'b1;
    repeat (k) @(posedge clk);
    @(negedge clk); ext_trig = 1'b0;
    repeat (20) @(posedge clk);
    #2;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    int v;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1 reset state
    chk("R1 eoc", eoc, 0); chk("R1 hold", sh_hold, 0); chk("R1 start", adc_start, 0);
    chk("R1 irq", irq, 0); chk("R1 dma", dma_req, 0); chk("R1 chan", adc_chan, 0);
    rd(2'd3, v); chk("R1 cmd", v, 0);
    rd(2'd0, v); chk("R1 lo", v, 0);
    rd(2'd1, v); chk("R1 hi", v, 0);

    // R2 host-write start, one-cycle pulse
    wr(2'd0, 8'h5C);
    chk("R2 start", adc_start, 1); chk("R2 eoc", eoc, 1); chk("R2 hold", sh_hold, 1);
    rd(2'd3, v); chk("R10 status busy", v, 8'h80);
    chk("R2 pulse width", adc_start, 0);
    // R5 lockout
    wr(2'd0, 8'h00); chk("R5 no restart", adc_start, 0);
    wr(2'd3, 8'h02); tick(); chk("R5 tick ignored", adc_start, 0);
    chk("R5 still busy", eoc, 1);
    wr(2'd3, 8'h00);
    // R6 capture and ignore idle done
    finish_conv(12'h5A3);
    chk("R6 eoc low", eoc, 0); chk("R6 hold low", sh_hold, 0);
    finish_conv(12'h111);
    rd(2'd0, v); chk("R6 lo", v, 8'hA3);
    rd(2'd1, v); chk("R6 hi", v, 8'h05);
    chk("R7 no irq when disabled", irq, 0); chk("R8 no dma when disabled", dma_req, 0);

    // R6 sweep of result values
    for (int r = 0; r < 4096 + 13; r += 13) begin
      int val;
      val = (r > 4095) ? 4095 : r;
      wr(2'd0, 8'h00);
      finish_conv(12'(val));
      rd(2'd0, v); chk("R6 sweep lo", v, val % 256);
      rd(2'd1, v); chk("R6 sweep hi", v, val / 256);
    end

    // R9 channel sweep both modes
    for (int m = 0; m < 2; m++) begin
      @(negedge clk); cfg_diff = m[0];
      for (int c = 0; c < 16; c++) begin
        int exp_c;
        exp_c = (m == 1) ? (c % 8) : c;
        wr(2'd2, 8'(c + 8'hF0));
        chk("R9 adc_chan", adc_chan, exp_c);
        rd(2'd2, v); chk("R9 readback", v, m * 16 + exp_c);
      end
    end
    @(negedge clk); cfg_diff = 1'b0;

    // R10 command readback
    wr(2'd3, 8'hFD); rd(2'd3, v); chk("R10 cmd bits", v, 8'h1D);

    // R3 external trigger qualification
    wr(2'd3, 8'h01);
    ext_pulse(10); chk("R3 200ns rejected", eoc, 0);
    ext_pulse(11); chk("R3 220ns accepted", eoc, 1);
    finish_conv(12'h0F0);
    @(negedge clk); ext_trig = 1'b1;
    repeat (20) @(posedge clk); #2 chk("R3 long level starts", eoc, 1);
    finish_conv(12'h0F1);
    repeat (20) @(posedge clk); #2 chk("R3 one start per level", eoc, 0);
    @(negedge clk); ext_trig = 1'b0;
    repeat (4) @(posedge clk);
    wr(2'd0, 8'h00); chk("R2 write ignored in ext mode", eoc, 0);

    // R3 pin inert in host-write mode; R4 not in host-write mode
    wr(2'd3, 8'h00);
    ext_pulse(15); chk("R3 ext ignored in sw mode", eoc, 0);
    tick(); chk("R4 tick ignored in sw mode", eoc, 0);

    // R4 timer and gating
    wr(2'd3, 8'h02); tick(); chk("R4 tick starts", eoc, 1);
    finish_conv(12'h001);
    wr(2'd3, 8'h06); tick(); chk("R4 gated tick blocked", eoc, 0);
    @(negedge clk); ext_trig = 1'b1;
    repeat (4) @(posedge clk);
    tick(); chk("R4 gated tick passes", eoc, 1);
    finish_conv(12'h002);
    @(negedge clk); ext_trig = 1'b0;
    repeat (4) @(posedge clk);

    // R11 reserved mode
    wr(2'd3, 8'h03);
    wr(2'd0, 8'h00); tick(); ext_pulse(15);
    chk("R11 no start", eoc, 0);

    // R7 interrupt
    wr(2'd3, 8'h08); wr(2'd0, 8'h00); finish_conv(12'h3C4);
    chk("R7 irq set", irq, 1);
    rd(2'd0, v); chk("R7 irq kept after low read", irq, 1);
    rd(2'd1, v); chk("R7 irq cleared", irq, 0); chk("R7 hi", v, 8'h03);

    // R8 DMA handshake
    wr(2'd3, 8'h10); wr(2'd0, 8'h00); finish_conv(12'h7E5);
    chk("R8 req set", dma_req, 1); chk("R8 no irq", irq, 0);
    repeat (3) @(posedge clk); #2 chk("R8 req held", dma_req, 1);
    @(negedge clk); dma_ack = 1'b1;
    @(posedge clk); #2 dma_ack = 1'b0;
    chk("R8 req cleared", dma_req, 0);

    summary();
  end
endmodule